// File: doc/BRIEF.md
# Register-Mapped Serial Port (8N1)

This block is an asynchronous serial port attached to a simple register port. Software starts a transmission by writing a byte to the data register. It collects a received byte by reading that same register. A status word shows whether the transmitter is still sending and whether a received byte is waiting. A 13-bit divider sets the bit time. A one-bit selector picks which of two receive pins feeds the receiver. A ready-to-send output tells the far end to pause while a received byte has not been read.

Frames are 8N1: one low start bit, eight data bits least significant first, and one high stop bit. Every bit lasts divider+1 clock cycles. The receiver passes the selected pin through a two-flop synchroniser. It re-checks the start bit half a bit after the falling edge, then samples each data bit and the stop bit at mid-bit. A good byte is kept in a single holding register. Any new good byte overwrites it.

Registers are decoded from address bits [3:2]. Data is at offset 0x0, status at 0x4, divider at 0x8 and receive-pin select at 0xC. Read data is combinational from the current address. Reset is synchronous and active high.

Top module: `uart_regport`

## Requirements
- R1: After reset, tx_line is 1, rts_n is 0, status (offset 0x4) reads 0, the divider (offset 0x8) reads the parameter DIV_RST (default 24), and the select register (offset 0xC) reads 0.
- R2: A write to offset 0x0 while the transmitter is idle sends the frame on tx_line from the next cycle. The frame is start bit 0, then wdata[7:0] least significant bit first, then stop bit 1, each held divider+1 cycles. tx_line is 1 whenever idle.
- R3: Status bit 0 (transmit busy) is 1 for exactly 10*(divider+1) cycles, starting the cycle after the accepted write.
- R4: A write to offset 0x0 while status bit 0 is 1 is ignored: the frame in flight continues unchanged and no second frame follows.
- R5: Offset 0x8 is a read/write 13-bit divider. Bits 31:13 read as 0 whatever was written.
- R6: Offset 0xC bit 0 selects the receive pin: 0 selects rx_main and 1 selects rx_alt. Other bits read 0. Activity on the pin that is not selected is ignored.
- R7: A low level on the selected pin that has gone high again by the half-bit check (divider>>1 cycles after it is seen by the synchroniser) is not treated as a start bit and yields no byte.
- R8: A frame whose stop bit samples as 1 loads its byte into the holding register and sets status bit 1. The byte reads at offset 0x0, and bit 1 stays set until the holding register is read.
- R9: A frame whose stop bit samples as 0 is discarded: status bit 1 stays 0.
- R10: A read (bus_rd) of offset 0x0 clears status bit 1 from the next cycle. rts_n is 1 exactly while status bit 1 is set.
- R11: If a byte completes in the same cycle as a read of offset 0x0, the new byte is kept and status bit 1 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effect on offset 0x0) |
| bus_addr | input | ADDR_W (4) | Byte offset; bits [3:2] select the register |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data for the addressed register |
| tx_line | output | 1 | Serial transmit output |
| rx_main | input | 1 | Default receive pin |
| rx_alt | input | 1 | Alternate receive pin |
| rts_n | output | 1 | High while a received byte is unread |

## Verification
The receiver finishing a byte and software reading the data register can fall in the same cycle. The read clears the available flag and the finished byte sets it. The bench gets there by counting clocks from the start edge it drives. It asserts the read exactly in the stop-bit sample cycle of a second frame while the first byte is still unread. It then expects the flag still set and the data register holding the second byte. A write attempt in the middle of a transmit frame is judged the same way against a per-cycle model of the line.

// File: rtl/uart_pkg.sv
package uart_pkg;

    localparam int UART_DATA_W = 8;
    localparam int UART_DIV_W  = 13;

    // register selected by address bits [3:2]
    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_RXPIN = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RXS_IDLE,
        RXS_START,
        RXS_DATA,
        RXS_STOP
    } rx_state_e;

    typedef struct packed {
        logic                   valid;
        logic [UART_DATA_W-1:0] data;
    } rx_byte_t;

    function automatic int frame_bits(input int data_w);
        return data_w + 2;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_pkg::*;
#(
    parameter int DATA_W = UART_DATA_W,
    parameter int DIV_W  = UART_DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic [DIV_W-1:0]  div,
    output logic              busy,
    output logic              at_end,
    output logic              tx
);
    localparam int NBITS = frame_bits(DATA_W);
    localparam int IDX_W = $clog2(NBITS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBITS - 1);

    logic [NBITS-1:0] shreg;
    logic [IDX_W-1:0] bit_idx;
    logic [DIV_W-1:0] bcnt;
    logic             tick;

    assign tick   = (bcnt == div);
    assign at_end = busy && tick && (bit_idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            shreg   <= '1;
            bit_idx <= '0;
            bcnt    <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                shreg   <= {1'b1, data, 1'b0};
                bit_idx <= '0;
                bcnt    <= '0;
            end
        end else if (tick) begin
            bcnt  <= '0;
            shreg <= {1'b1, shreg[NBITS-1:1]};
            if (bit_idx == LAST) busy <= 1'b0;
            else                 bit_idx <= bit_idx + 1'b1;
        end else begin
            bcnt <= bcnt + 1'b1;
        end
    end

    assign tx = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
    import uart_pkg::*;
#(
    parameter int DATA_W = UART_DATA_W,
    parameter int DIV_W  = UART_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxs,
    input  logic [DIV_W-1:0] div,
    output rx_byte_t         result
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

    rx_state_e         state;
    logic [DIV_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic [DIV_W-1:0]  half;

    assign half = div >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RXS_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            case (state)
                RXS_IDLE: begin
                    if (!rxs) begin
                        state <= RXS_START;
                        cnt   <= '0;
                    end
                end
                RXS_START: begin
                    if (cnt == half) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= rxs ? RXS_IDLE : RXS_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RXS_DATA: begin
                    if (cnt == div) begin
                        cnt   <= '0;
                        shreg <= {rxs, shreg[DATA_W-1:1]};
                        if (bit_idx == LAST) state <= RXS_STOP;
                        else                 bit_idx <= bit_idx + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RXS_STOP: begin
                    if (cnt == div) begin
                        cnt   <= '0;
                        state <= RXS_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RXS_IDLE;
            endcase
        end
    end

    always_comb begin
        result.valid = (state == RXS_STOP) && (cnt == div) && rxs;
        result.data  = shreg;
    end
endmodule

// File: rtl/uart_regport.sv
module uart_regport
    import uart_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int ADDR_W      = 4,
    parameter int DIV_W       = UART_DIV_W,
    parameter int DIV_RST     = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tx_line,
    input  logic              rx_main,
    input  logic              rx_alt,
    output logic              rts_n
);
    localparam int DW = UART_DATA_W;

    reg_sel_e         sel;
    logic [DIV_W-1:0] div_q;
    logic             rxpin_q;
    logic             tx_busy;
    logic             tx_at_end;
    logic             rx_pin;
    logic             rx_synced;
    rx_byte_t         rx_res;
    logic             rx_done;
    logic             rx_avail;
    logic [DW-1:0]    rx_hold;
    logic             wr_data;
    logic             rd_data;

    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign wr_data = bus_wr && (sel == SEL_DATA);
    assign rd_data = bus_rd && (sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= DIV_W'(DIV_RST);
            rxpin_q <= 1'b0;
        end else if (bus_wr) begin
            if (sel == SEL_DIV)   div_q   <= bus_wdata[DIV_W-1:0];
            if (sel == SEL_RXPIN) rxpin_q <= bus_wdata[0];
        end
    end

    uart_tx_engine #(.DATA_W(DW), .DIV_W(DIV_W)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .start  (wr_data),
        .data   (bus_wdata[DW-1:0]),
        .div    (div_q),
        .busy   (tx_busy),
        .at_end (tx_at_end),
        .tx     (tx_line)
    );

    assign rx_pin = rxpin_q ? rx_alt : rx_main;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_pin),
        .dout (rx_synced)
    );

    uart_rx_engine #(.DATA_W(DW), .DIV_W(DIV_W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .rxs    (rx_synced),
        .div    (div_q),
        .result (rx_res)
    );

    assign rx_done = rx_res.valid;

    // a finishing byte takes priority over a clearing read
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_avail <= 1'b0;
            rx_hold  <= '0;
        end else if (rx_done) begin
            rx_avail <= 1'b1;
            rx_hold  <= rx_res.data;
        end else if (rd_data) begin
            rx_avail <= 1'b0;
        end
    end

    assign rts_n = rx_avail;

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_DATA:  bus_rdata[DW-1:0]    = rx_hold;
            SEL_STAT:  bus_rdata[1:0]       = {rx_avail, tx_busy};
            SEL_DIV:   bus_rdata[DIV_W-1:0] = div_q;
            SEL_RXPIN: bus_rdata[0]         = rxpin_q;
            default:   bus_rdata            = '0;
        endcase
    end
endmodule

// File: rtl/uart_regport_chk.sv
module uart_regport_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tx_line,
    input logic              tx_busy,
    input logic              tx_at_end,
    input logic              rx_done,
    input logic              rx_avail
);
    logic hit_data;
    assign hit_data = (bus_addr[3:2] == 2'd0);

    // R2: idle line is high
    p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_line);

    // R2: a frame opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !tx_line);

    // R4: a data write mid-frame cannot cut the frame short
    p_wr_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !tx_at_end && bus_wr && hit_data) |=> tx_busy);

    // R8: the flag persists until a read
    p_avail_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_avail && !(bus_rd && hit_data)) |=> rx_avail);

    // R10: a read with no new byte clears the flag
    p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit_data && !rx_done) |=> !rx_avail);

    // R11: a finishing byte always leaves the flag set
    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> rx_avail);
endmodule

bind uart_regport uart_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .tx_line   (tx_line),
    .tx_busy   (tx_busy),
    .tx_at_end (tx_at_end),
    .rx_done   (rx_done),
    .rx_avail  (rx_avail)
);

// File: tb/uart_regport_tb.sv
module uart_regport_tb;
    localparam int CLK_NS  = 10;
    localparam int DIV_RST = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = 4'h4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_line;
    logic        rx_main = 1'b1;
    logic        rx_alt = 1'b1;
    logic        rts_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    uart_regport #(.DIV_RST(DIV_RST)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_line(tx_line), .rx_main(rx_main), .rx_alt(rx_alt), .rts_n(rts_n)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural transmit model: elapsed cycles since the accepted write
    bit       m_busy = 0;
    int       m_el   = 0;
    int       m_div  = DIV_RST;
    bit [9:0] m_frame = '1;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_el = 0; m_div = DIV_RST;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            if (m_busy) begin
                m_el++;
                if (m_el == 10 * (m_div + 1)) m_busy = 0;
            end
            if (!was_busy && bus_wr && bus_addr[3:2] == 2'd0) begin
                m_busy  = 1;
                m_el    = 0;
                m_frame = {1'b1, bus_wdata[7:0], 1'b0};
            end
            if (bus_wr && bus_addr[3:2] == 2'd2) m_div = int'(bus_wdata[12:0]);
        end
    end

    // per-cycle comparison of the line and busy flag (R2, R3, R4)
    always @(negedge clk) begin
        if (!rst && !ended) begin
            bit exp_tx;
            exp_tx = m_busy ? m_frame[m_el / (m_div + 1)] : 1'b1;
            chk(tx_line == exp_tx, "R2/R4 tx_line", int'(tx_line), int'(exp_tx));
            if (bus_addr == 4'h4 && !bus_wr)
                chk(bus_rdata[0] == m_busy, "R3 busy", int'(bus_rdata[0]), int'(m_busy));
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'h4;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_addr = 4'h4;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 4'h4;
    endtask

    // drive one frame on a pin, starting at the current negedge
    task automatic send_rx(input bit alt, input logic [7:0] b, input bit stopv, input int d);
        for (int j = 0; j < 10; j++) begin
            bit v;
            v = (j == 0) ? 1'b0 : ((j == 9) ? stopv : b[j-1]);
            if (alt) rx_alt = v; else rx_main = v;
            repeat (d + 1) @(negedge clk);
        end
        if (alt) rx_alt = 1'b1; else rx_main = 1'b1;
    endtask

    task automatic wait_tx_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk(tx_line == 1'b1, "R1 tx idle", int'(tx_line), 1);
        chk(rts_n == 1'b0, "R1 rts_n", int'(rts_n), 0);
        peek(4'h4, r); chk(r == 0, "R1 status", r, 0);
        peek(4'h8, r); chk(r == DIV_RST, "R1 divider", r, DIV_RST);
        peek(4'hC, r); chk(r == 0, "R1 rx select", r, 0);

        // R5 divider width
        bus_write(4'h8, 32'hFFFF_FFFF);
        peek(4'h8, r); chk(r == 32'h1FFF, "R5 divider mask", r, 32'h1FFF);
        bus_write(4'h8, 32'd2);
        peek(4'h8, r); chk(r == 2, "R5 divider value", r, 2);

        // R6 select register width
        bus_write(4'hC, 32'hFF);
        peek(4'hC, r); chk(r == 1, "R6 select mask", r, 1);
        bus_write(4'hC, 32'h0);

        // R2/R3 transmit with divider 2
        bus_write(4'h0, 32'h01);
        wait_tx_idle();

        // R2/R4 transmit with divider 5, write mid-frame ignored
        bus_write(4'h8, 32'd5);
        bus_write(4'h0, 32'hA5);
        repeat (17) @(negedge clk);
        bus_write(4'h0, 32'h3C);
        wait_tx_idle();
        repeat (5) @(negedge clk);
        chk(tx_line == 1'b1, "R4 no second frame", int'(tx_line), 1);
        bus_write(4'h0, 32'hFE);
        wait_tx_idle();

        d = 5;
        // R8/R10 normal reception on rx_main
        @(negedge clk);
        send_rx(1'b0, 8'h5A, 1'b1, d);
        repeat (4) @(negedge clk);
        peek(4'h4, r); chk(r[1] == 1'b1, "R8 avail", int'(r[1]), 1);
        chk(rts_n == 1'b1, "R10 rts_n while held", int'(rts_n), 1);
        peek(4'h0, r); chk(r[7:0] == 8'h5A, "R8 data", int'(r[7:0]), 'h5A);
        peek(4'h4, r); chk(r[1] == 1'b1, "R8 peek keeps flag", int'(r[1]), 1);
        bus_read(4'h0, r); chk(r[7:0] == 8'h5A, "R8 read data", int'(r[7:0]), 'h5A);
        peek(4'h4, r); chk(r[1] == 1'b0, "R10 cleared", int'(r[1]), 0);
        chk(rts_n == 1'b0, "R10 rts_n released", int'(rts_n), 0);

        // R6 unselected pin ignored, then selected
        @(negedge clk);
        send_rx(1'b1, 8'hC3, 1'b1, d);
        repeat (6) @(negedge clk);
        peek(4'h4, r); chk(r[1] == 1'b0, "R6 alt ignored", int'(r[1]), 0);
        bus_write(4'hC, 32'h1);
        @(negedge clk);
        send_rx(1'b1, 8'hC3, 1'b1, d);
        repeat (4) @(negedge clk);
        bus_read(4'h0, r); chk(r[7:0] == 8'hC3, "R6 alt received", int'(r[7:0]), 'hC3);
        bus_write(4'hC, 32'h0);

        // R7 short low pulse is not a start
        @(negedge clk);
        rx_main = 1'b0;
        @(negedge clk);
        rx_main = 1'b1;
        repeat (80) @(negedge clk);
        peek(4'h4, r); chk(r[1] == 1'b0, "R7 glitch rejected", int'(r[1]), 0);

        // R9 bad stop bit
        @(negedge clk);
        send_rx(1'b0, 8'h77, 1'b0, d);
        repeat (20) @(negedge clk);
        peek(4'h4, r); chk(r[1] == 1'b0, "R9 framing discard", int'(r[1]), 0);

        // R11 byte completes in the read cycle
        @(negedge clk);
        send_rx(1'b0, 8'h11, 1'b1, d);
        repeat (6) @(negedge clk);
        fork
            send_rx(1'b0, 8'h22, 1'b1, d);
            begin
                repeat ((d >> 1) + 3 + 9 * (d + 1)) @(negedge clk);
                bus_addr = 4'h0; bus_rd = 1'b1;
                @(negedge clk);
                bus_rd = 1'b0; bus_addr = 4'h4;
            end
        join
        repeat (3) @(negedge clk);
        peek(4'h4, r); chk(r[1] == 1'b1, "R11 flag kept", int'(r[1]), 1);
        peek(4'h0, r); chk(r[7:0] == 8'h22, "R11 new byte", int'(r[7:0]), 'h22);

        repeat (5) @(negedge clk);
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule